// File: doc/BRIEF.md
# Flash Write Staging Buffer

This block gathers the data of one serial flash program operation before it is sent. A host pushes 32-bit words through a memory-mapped write port. The port uses waitrequest backpressure. The words collect in an internal first-in first-out store that holds `DEPTH` words, which is 1024 by default, or 4 KB.

A two-bit operation command either discards the stored words or starts the transfer. During the transfer the block sends the words out in the order they arrived. Each word goes out as four bytes on an 8-bit valid/ready stream toward the flash engine. Each byte has its bit order mirrored on the way out.

The block reports the current fill level and a busy flag. When an operation ends it gives a one-cycle done pulse and a response status. If the flash side signals an error, the transfer stops, the remaining words are discarded and a sticky error bit is set. The host clears that bit by writing 1 to it.

Top module: `flash_wr_stage`

## Requirements
- R1: After reset the fill level is 0, `busy_o`, `done_o`, `err_o`, `rsp_ok_o` and `tx_valid_o` are 0, and `wr_wait_o` is 0.
- R2: A word is stored only on a clock edge where `wr_req_i` is 1 and `wr_wait_o` is 0. Each stored word raises the fill level by one. When `DEPTH` words are held, the fill level equals `DEPTH` and `wr_wait_o` stays 1.
- R3: Opcode 2'b10 on `op_code_i` with `op_valid_i`, while not busy, empties the store. The fill level reads 0 after that edge. `wr_wait_o` is 1 in any cycle that presents opcode 2'b01 or 2'b10.
- R4: Opcode 2'b01, while not busy and with words stored, raises `busy_o` after that edge. The words are then sent in arrival order, each as four bytes with bits 7:0 first and bits 31:24 last. Every sent byte has its bits mirrored: `tx_data_o[i]` equals bit `7-i` of the source byte.
- R5: While `tx_valid_o` is 1 and `tx_ready_i` is 0, `tx_valid_o` and `tx_data_o` hold their values into the next cycle.
- R6: On the edge where the last byte is accepted (`tx_valid_o` and `tx_ready_i` both 1), `busy_o` falls and `rsp_ok_o` becomes 1. At that point the fill level is 0 and `done_o` is 1 for exactly one cycle.
- R7: Opcode 2'b01 with an empty store completes on that edge: `done_o` pulses, `rsp_ok_o` becomes 1 and `busy_o` stays 0.
- R8: Opcodes 2'b00 and 2'b11 have no effect: the fill level, `busy_o` and `done_o` are unchanged.
- R9: While `busy_o` is 1, `wr_wait_o` is 1, and every opcode is ignored.
- R10: `tx_err_i` high during a transfer ends it on that edge. The fill level becomes 0, `busy_o` and `tx_valid_o` become 0, `err_o` becomes 1, `rsp_ok_o` becomes 0 and `done_o` pulses.
- R11: `err_o` stays 1 until a cycle with `err_clr_i` at 1, after which it reads 0. `tx_err_i` outside a transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Write request of the memory-mapped port |
| wr_data_i | input | 32 | Write data word |
| wr_wait_o | output | 1 | Waitrequest; a word is taken only when low |
| op_valid_i | input | 1 | Operation command strobe |
| op_code_i | input | 2 | 01 start, 10 flush, others ignored |
| fill_level_o | output | 11 | Number of words stored |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when an operation ends |
| rsp_ok_o | output | 1 | Outcome of last transfer, 1 = success |
| err_o | output | 1 | Sticky transfer error |
| err_clr_i | input | 1 | Write 1 to clear `err_o` |
| tx_valid_o | output | 1 | Byte stream valid |
| tx_data_o | output | 8 | Bit-mirrored byte |
| tx_ready_i | input | 1 | Byte stream ready |
| tx_err_i | input | 1 | Flash-side error, aborts a transfer |

## Verification
Random 32-bit words are drained at several acceptance rates. A full-rate drain exposes lost or repeated bytes at word boundaries. Sparse random ready exposes data that changes while stalled and byte-lane order errors. A full 1024-word load followed by a drain tests the capacity limit and pointer wrap. Directed cases cover flush, the ignored opcodes, a start with nothing stored, commands and writes issued mid-transfer, and an abort after a partial transfer. These separate a correct response status from one that only reflects the last event.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_START = 2'b01,
    OP_FLUSH = 2'b10,
    OP_RSVD  = 2'b11
  } wr_op_e;

  function automatic logic [7:0] bit_rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/fws_fifo.sv
module fws_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 1024,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [W-1:0]     head_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  // DEPTH must be a power of two: pointers wrap naturally
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] cnt_q;

  assign head_o  = mem[rd_ptr_q];
  assign level_o = cnt_q;
  assign full_o  = (cnt_q == LVL_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_flush_empties_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/fws_serializer.sv
module fws_serializer #(
  parameter int W = 32,
  localparam int BYTES = W / 8,
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         ready_i,
  input  logic         abort_i,
  output logic         valid_o,
  output logic [7:0]   byte_o,
  output logic         last_o
);
  import flash_wr_pkg::*;

  logic [W-1:0]     word_q;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;
  logic [7:0]       lane_rev [BYTES];

  // low lane leaves first, each lane mirrored
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lane_rev[g] = bit_rev8(word_q[g*8 +: 8]);
  end

  assign valid_o = valid_q;
  assign byte_o  = lane_rev[idx_q];
  assign last_o  = (idx_q == IDX_W'(BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (abort_i) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (load_i) begin
      word_q  <= word_i;
      idx_q   <= '0;
      valid_q <= 1'b1;
    end else if (valid_q && ready_i) begin
      if (last_o) valid_q <= 1'b0;
      else        idx_q   <= idx_q + 1'b1;
    end
  end

  p_hold_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !abort_i) |=> (valid_o && $stable(byte_o)));
endmodule

// File: rtl/flash_wr_stage.sv
module flash_wr_stage #(
  parameter int DEPTH = 1024,
  localparam int W     = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  logic [W-1:0]     wr_data_i,
  output logic             wr_wait_o,
  input  logic             op_valid_i,
  input  logic [1:0]       op_code_i,
  output logic [LVL_W-1:0] fill_level_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             rsp_ok_o,
  output logic             err_o,
  input  logic             err_clr_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  input  logic             tx_ready_i,
  input  logic             tx_err_i
);
  import flash_wr_pkg::*;

  logic drain_q, done_q, rsp_ok_q, err_q;
  logic full, empty, push, pop, flush;
  logic [W-1:0] head;
  logic ser_valid, ser_last;
  logic op_start, op_flush, op_cmd, abort, load, tx_acc, finish;

  assign op_cmd   = op_valid_i && (op_code_i == OP_START || op_code_i == OP_FLUSH);
  assign op_start = op_valid_i && (op_code_i == OP_START) && !drain_q;
  assign op_flush = op_valid_i && (op_code_i == OP_FLUSH) && !drain_q;

  // commands own the store for their cycle; no write slips in beside them
  assign wr_wait_o = full || drain_q || op_cmd;
  assign push      = wr_req_i && !wr_wait_o;

  assign tx_acc = ser_valid && tx_ready_i;
  assign abort  = drain_q && tx_err_i;
  assign load   = drain_q && !abort && !empty && (!ser_valid || (tx_acc && ser_last));
  assign pop    = load;
  assign flush  = op_flush || abort;
  assign finish = drain_q && !abort && empty && tx_acc && ser_last;

  fws_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (wr_data_i),
    .pop_i       (pop),
    .flush_i     (flush),
    .head_o      (head),
    .level_o     (fill_level_o),
    .full_o      (full),
    .empty_o     (empty)
  );

  fws_serializer #(.W(W)) i_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .word_i  (head),
    .ready_i (tx_ready_i),
    .abort_i (abort),
    .valid_o (ser_valid),
    .byte_o  (tx_data_o),
    .last_o  (ser_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q  <= 1'b0;
      done_q   <= 1'b0;
      rsp_ok_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= finish || abort || (op_start && empty);
      if (op_start && !empty)  drain_q <= 1'b1;
      else if (finish || abort) drain_q <= 1'b0;
      if (abort)                               rsp_ok_q <= 1'b0;
      else if (finish || (op_start && empty)) rsp_ok_q <= 1'b1;
      if (abort)          err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign busy_o     = drain_q;
  assign done_o     = done_q;
  assign rsp_ok_o   = rsp_ok_q;
  assign err_o      = err_q;
  assign tx_valid_o = ser_valid;

  p_wait_when_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_level_o == LVL_W'(DEPTH)) |-> wr_wait_o);
  p_busy_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> wr_wait_o);
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && fill_level_o == '0 || $past(op_valid_i)));
  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tx_err_i) |=> (err_o && !busy_o && !tx_valid_o && !rsp_ok_o));
  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
  p_idle_no_tx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tx_valid_o);
endmodule

// File: tb/test_flash_wr_stage.sv
`timescale 1ns/1ps
module test_flash_wr_stage;
  localparam int DEPTH = 1024;
  localparam int LVL_W = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic wr_req = 0, op_valid = 0, err_clr = 0, tx_ready = 0, tx_err = 0;
  logic [31:0] wr_data = '0;
  logic [1:0]  op_code = '0;
  logic wr_wait, busy, done, rsp_ok, err, tx_valid;
  logic [7:0] tx_data;
  logic [LVL_W-1:0] level;

  flash_wr_stage #(.DEPTH(DEPTH)) i_flash_wr_stage (
    .clk_i(clk), .rst_ni(rst_n), .wr_req_i(wr_req), .wr_data_i(wr_data),
    .wr_wait_o(wr_wait), .op_valid_i(op_valid), .op_code_i(op_code),
    .fill_level_o(level), .busy_o(busy), .done_o(done), .rsp_ok_o(rsp_ok),
    .err_o(err), .err_clr_i(err_clr), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_ready_i(tx_ready), .tx_err_i(tx_err)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] model[$];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic push_word(input logic [31:0] d);
    wr_req = 1; wr_data = d; #1;
    while (wr_wait) begin cyc(); #1; end
    cyc();
    wr_req = 0;
    model.push_back(d);
  endtask

  task automatic op(input logic [1:0] c);
    op_valid = 1; op_code = c;
    cyc();
    op_valid = 0;
  endtask

  // drain with given ready percentage; poke issues a write and a flush mid-transfer
  task automatic drain(input int pct, input bit poke);
    int idx = 0, guard = 0, bad = 0;
    bit hold = 0, poked = 0;
    logic [7:0] prev = '0, exp;
    chk("R4 busy after start", busy, 1);
    while (busy && guard < 100000) begin
      tx_ready = ($urandom % 100) < pct;
      #1;
      if (hold && !(tx_valid && tx_data == prev)) begin
        bad++;
        chk("R5 stalled byte held", tx_data, prev);
      end
      if (tx_valid && tx_ready) begin
        exp = rev8(model[idx/4][8*(idx%4) +: 8]);
        if (tx_data != exp) begin
          bad++;
          chk("R4 byte order/mirror", tx_data, exp);
        end
        idx++;
      end
      hold = tx_valid && !tx_ready;
      prev = tx_data;
      if (poke && !poked && idx == 2) begin
        poked = 1;
        wr_req = 1; op_valid = 1; op_code = 2'b10; #0.5;
        chk("R9 wait high while busy", wr_wait, 1);
      end
      cyc();
      wr_req = 0; op_valid = 0;
      guard++;
    end
    tx_ready = 0;
    chk("R4 R5 stream errors", bad, 0);
    chk("R6 byte count", idx, 4 * model.size());
    chk("R6 done on finish", done, 1);
    chk("R6 rsp ok", rsp_ok, 1);
    chk("R6 level zero", level, 0);
    cyc();
    chk("R6 done one cycle", done, 0);
    model.delete();
  endtask

  initial begin
    #(5.0 * 190000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #12; rst_n = 1; #1;
    chk("R1 level", level, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 rsp_ok", rsp_ok, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 wait", wr_wait, 0);
    cyc();

    // R2 / R4 / R6 full rate
    for (int i = 0; i < 3; i++) push_word($urandom);
    chk("R2 level count", level, 3);
    op(2'b01);
    drain(100, 0);

    // R5 / R9 sparse ready with mid-transfer poke
    for (int i = 0; i < 7; i++) push_word($urandom);
    op(2'b01);
    drain(40, 1);
    chk("R9 poked write not stored", level, 0);

    // R3 flush
    for (int i = 0; i < 4; i++) push_word($urandom);
    op_valid = 1; op_code = 2'b10; #1;
    chk("R3 wait during command", wr_wait, 1);
    cyc(); op_valid = 0;
    chk("R3 flush level", level, 0);
    model.delete();

    // R8 ignored opcodes
    for (int i = 0; i < 2; i++) push_word($urandom);
    op(2'b00);
    chk("R8 op00 level", level, 2);
    chk("R8 op00 done", done, 0);
    op(2'b11);
    chk("R8 op11 level", level, 2);
    chk("R8 op11 busy", busy, 0);
    chk("R8 op11 done", done, 0);
    op(2'b10); model.delete();

    // R10 abort
    for (int i = 0; i < 5; i++) push_word($urandom);
    op(2'b01);
    tx_ready = 1;
    for (int i = 0; i < 6; i++) cyc();
    tx_ready = 0; tx_err = 1;
    cyc(); tx_err = 0;
    chk("R10 busy", busy, 0);
    chk("R10 err", err, 1);
    chk("R10 rsp_ok", rsp_ok, 0);
    chk("R10 level", level, 0);
    chk("R10 tx_valid", tx_valid, 0);
    chk("R10 done", done, 1);
    model.delete();

    // R11 sticky and clear
    for (int i = 0; i < 3; i++) cyc();
    chk("R11 err sticky", err, 1);
    tx_err = 1; cyc(); tx_err = 0;
    chk("R11 idle tx_err no effect", done, 0);
    err_clr = 1; cyc(); err_clr = 0;
    chk("R11 err cleared", err, 0);
    tx_err = 1; cyc(); tx_err = 0;
    chk("R11 idle tx_err no set", err, 0);

    // R7 start on empty
    op(2'b01);
    chk("R7 done", done, 1);
    chk("R7 rsp_ok", rsp_ok, 1);
    chk("R7 busy", busy, 0);

    // R2 capacity, then full drain
    for (int i = 0; i < DEPTH; i++) push_word($urandom);
    wr_req = 1; #1;
    chk("R2 full level", level, DEPTH);
    chk("R2 wait when full", wr_wait, 1);
    cyc(); wr_req = 0;
    chk("R2 no extra word", level, DEPTH);
    op(2'b01);
    drain(70, 0);

    summary();
  end
endmodule